// File: doc/BRIEF.md
# Instruction Fetch PC Sequencer

This block produces the program-store fetch address for a small 8-bit processor core. The program store has its own address and data bus, separate from data memory and the register space. The block holds a 16-bit program counter. The counter moves forward by the byte length of each instruction, or it loads a jump target. A sequential step that carries out of the low address byte into the high byte costs one extra clock. In that clock the high byte is incremented and the stall output is asserted. A jump loads the whole address in one clock, whatever page it leaves or lands on.

The instruction-issue logic drives the step strobe with the instruction length and, for a jump, the jump request and target. It waits for the one-cycle done pulse before it presents the next instruction. While stall is high the strobe is not accepted. During that cycle the fetch address carries the new low byte together with the old high byte, so it must not be used.

Top module: `pc_fetch_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the fetch address reads 0000h and both stall and done are low.
- R2: A sequential step accepted at a clock edge that does not carry out of the low byte gives fetch address = old address + length after that same edge. Length is the 2-bit length input, 1 to 3 bytes. Done is high for that one cycle and stall stays low.
- R3: A sequential step that carries out of the low byte works in two cycles. After the accepting edge, the low byte holds the new value, the high byte still holds the old value, stall is high and done is low. After the next edge, the high byte is incremented, stall is low and done is high.
- R4: An accepted jump, with the jump input high, loads the 16-bit target after the accepting edge with done high and stall low. This holds even when the target lands on or crosses a 256-byte page boundary.
- R5: The step strobe, length, jump and target inputs are ignored during a cycle in which stall is high. The step in progress completes exactly as it would without them, and no extra done pulse follows.
- R6: A sequential step past FFFFh wraps around to the bottom of the address space: FFFEh + 3 gives 0001h, taking the two-cycle carry path.
- R7: Done is a single-cycle pulse for each accepted instruction. With the strobe low, the fetch address holds and done stays low.
- R8: Crossing a 64-byte boundary inside a page, such as 003Eh + 2 giving 0040h, costs no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step strobe: accept the presented instruction |
| len_i | input | 2 | Instruction length in bytes (1 to 3) |
| jump_i | input | 1 | Load the target instead of stepping sequentially |
| target_i | input | 16 | Jump target address |
| fetch_addr_o | output | 16 | Registered program-store fetch address |
| stall_o | output | 1 | High during the extra high-byte increment cycle |
| done_o | output | 1 | One-cycle pulse when the new address is complete |

## Verification
The bench aims at the page-crossing steps: x0FEh + 2, a 3-byte step from xxFDh, and the wrap from FFFEh. A design that dropped the carry would return to the start of the old page. A design that skipped the stall would complete in one cycle, so the cycle count reported by the bench would be wrong. Jumps to page starts and to the last bytes of a page are checked to cost one cycle, which catches a design that charges the penalty on every high-byte change. A step strobe held high through the stall cycle with a jump presented shows whether a design wrongly takes it: the address would jump, or a second done pulse would appear. The 64-byte case exposes a penalty applied at the wrong carry bit.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [0:0] {
    SEQ_RUN   = 1'b0,
    SEQ_CARRY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pc_lo_add.sv
// Low-byte adder: adds the instruction length and reports the carry out.
module pc_lo_add #(
  parameter int LO_W  = 8,
  parameter int LEN_W = 2
) (
  input  logic [LO_W-1:0]  lo_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LO_W-1:0]  sum_o,
  output logic             carry_o
);
  localparam int EXT_W = LO_W + 1 - LEN_W;
  logic [LO_W:0] wide;

  always_comb begin
    wide    = {1'b0, lo_i} + {{EXT_W{1'b0}}, len_i};
    sum_o   = wide[LO_W-1:0];
    carry_o = wide[LO_W];
  end
endmodule

// File: rtl/pc_hi_inc.sv
// High-byte incrementer; wraps at the top of the address space.
module pc_hi_inc #(
  parameter int HI_W = 8
) (
  input  logic [HI_W-1:0] hi_i,
  output logic [HI_W-1:0] hi_o
);
  always_comb hi_o = hi_i + {{(HI_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/pc_seq_ctrl.sv
// Control: accepts steps, tracks the pending high-byte cycle, registers done.
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic jump_i,
  input  logic carry_i,
  output logic take_jump_o,
  output logic take_seq_o,
  output logic bump_hi_o,
  output logic stall_o,
  output logic done_o
);
  seq_state_e state_q, state_d;
  logic       accept;
  logic       done_d;

  always_comb begin
    accept      = step_i && (state_q == SEQ_RUN);
    take_jump_o = accept && jump_i;
    take_seq_o  = accept && !jump_i;
    bump_hi_o   = (state_q == SEQ_CARRY);
    state_d     = SEQ_RUN;
    if (take_seq_o && carry_i) state_d = SEQ_CARRY;
    done_d      = take_jump_o || (take_seq_o && !carry_i) || bump_hi_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_RUN;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
    end
  end

  assign stall_o = (state_q == SEQ_CARRY);
endmodule

// File: rtl/pc_fetch_seq.sv
// Program counter sequencer with a one-cycle penalty on sequential page carry.
module pc_fetch_seq #(
  parameter int PC_W      = 16,
  parameter int PAGE_BITS = 8,
  parameter int LEN_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             jump_i,
  input  logic [PC_W-1:0]  target_i,
  output logic [PC_W-1:0]  fetch_addr_o,
  output logic             stall_o,
  output logic             done_o
);
  localparam int LO_W = PAGE_BITS;
  localparam int HI_W = PC_W - PAGE_BITS;

  logic [LO_W-1:0] lo_q, lo_sum;
  logic [HI_W-1:0] hi_q, hi_next;
  logic            carry, take_jump, take_seq, bump_hi;

  pc_lo_add #(.LO_W(LO_W), .LEN_W(LEN_W)) u_lo_add (
    .lo_i(lo_q), .len_i(len_i), .sum_o(lo_sum), .carry_o(carry)
  );

  pc_hi_inc #(.HI_W(HI_W)) u_hi_inc (
    .hi_i(hi_q), .hi_o(hi_next)
  );

  pc_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .step_i(step_i), .jump_i(jump_i),
    .carry_i(carry), .take_jump_o(take_jump), .take_seq_o(take_seq),
    .bump_hi_o(bump_hi), .stall_o(stall_o), .done_o(done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (take_jump) begin
      lo_q <= target_i[LO_W-1:0];
      hi_q <= target_i[PC_W-1:LO_W];
    end else begin
      if (take_seq) lo_q <= lo_sum;
      if (bump_hi)  hi_q <= hi_next;
    end
  end

  assign fetch_addr_o = {hi_q, lo_q};
endmodule

// File: rtl/pc_fetch_seq_chk.sv
// Port-level checker, bound to the sequencer.
module pc_fetch_seq_chk #(
  parameter int PC_W      = 16,
  parameter int PAGE_BITS = 8,
  parameter int LEN_W     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             step_i,
  input logic [LEN_W-1:0] len_i,
  input logic             jump_i,
  input logic [PC_W-1:0]  target_i,
  input logic [PC_W-1:0]  fetch_addr_o,
  input logic             stall_o,
  input logic             done_o
);
  localparam int LO_W = PAGE_BITS;
  logic [LO_W:0] lo_sum_chk;
  assign lo_sum_chk = {1'b0, fetch_addr_o[LO_W-1:0]} + {{(LO_W+1-LEN_W){1'b0}}, len_i};

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (fetch_addr_o == '0 && !stall_o && !done_o));

  assert_seq_nocarry_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !stall_o && !jump_i && !lo_sum_chk[LO_W])
    |=> (fetch_addr_o == $past(fetch_addr_o) + PC_W'($past(len_i)) && done_o && !stall_o));

  assert_carry_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !stall_o && !jump_i && lo_sum_chk[LO_W]) |=> (stall_o && !done_o));

  assert_stall_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (!stall_o && done_o));

  assert_jump_load_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !stall_o && jump_i)
    |=> (fetch_addr_o == $past(target_i) && done_o && !stall_o));

  assert_stall_ignores_R5: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (fetch_addr_o[LO_W-1:0] == $past(fetch_addr_o[LO_W-1:0])));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !stall_o) |=> ($stable(fetch_addr_o) && !done_o));

  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done_o && stall_o));
endmodule

bind pc_fetch_seq pc_fetch_seq_chk #(
  .PC_W(PC_W), .PAGE_BITS(PAGE_BITS), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/tb_pc_fetch_seq.sv
module tb_pc_fetch_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic [1:0]  len_i = 2'd0;
  logic        jump_i = 1'b0;
  logic [15:0] target_i = 16'h0;
  logic [15:0] fetch_addr_o;
  logic        stall_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pc_fetch_seq dut (
    .clk(clk), .rst(rst), .step_i(step_i), .len_i(len_i), .jump_i(jump_i),
    .target_i(target_i), .fetch_addr_o(fetch_addr_o), .stall_o(stall_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {jump, len, target, expected address, expected cycles}
  localparam logic [36:0] VEC [12] = '{
    {1'b0, 2'd1, 16'h0000, 16'h0001, 2'd1},  // R2
    {1'b0, 2'd3, 16'h0000, 16'h0004, 2'd1},  // R2
    {1'b1, 2'd0, 16'h00FE, 16'h00FE, 2'd1},  // R4
    {1'b0, 2'd2, 16'h0000, 16'h0100, 2'd2},  // R3
    {1'b1, 2'd0, 16'h0200, 16'h0200, 2'd1},  // R4 lands on page start
    {1'b0, 2'd1, 16'h0000, 16'h0201, 2'd1},  // R2
    {1'b1, 2'd0, 16'h003E, 16'h003E, 2'd1},  // R4 crosses pages downward
    {1'b0, 2'd2, 16'h0000, 16'h0040, 2'd1},  // R8
    {1'b1, 2'd0, 16'hFFFE, 16'hFFFE, 2'd1},  // R4
    {1'b0, 2'd3, 16'h0000, 16'h0001, 2'd2},  // R6
    {1'b1, 2'd0, 16'h12FD, 16'h12FD, 2'd1},  // R4
    {1'b0, 2'd3, 16'h0000, 16'h1300, 2'd2}   // R3
  };

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 addr in reset", 32'(fetch_addr_o), 32'h0);
    chk("R1 stall/done in reset", {30'd0, stall_o, done_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 addr after reset", 32'(fetch_addr_o), 32'h0);

    for (int i = 0; i < 12; i++) begin
      logic [36:0] v;
      int cyc;
      bit saw_stall;
      v = VEC[i];
      step_i = 1'b1; jump_i = v[36]; len_i = v[35:34]; target_i = v[33:18];
      @(negedge clk);
      step_i = 1'b0;
      cyc = 1; saw_stall = 1'b0;
      while (!done_o && cyc < 8) begin
        if (stall_o) saw_stall = 1'b1;
        @(negedge clk);
        cyc++;
      end
      chk($sformatf("R2/R3/R4 vector %0d addr", i), 32'(fetch_addr_o), 32'(v[17:2]));
      chk($sformatf("R3/R8 vector %0d cycles", i), 32'(cyc), 32'(v[1:0]));
      chk($sformatf("R3 vector %0d stall seen", i), {31'd0, saw_stall}, {31'd0, v[1:0] == 2'd2});
    end

    // R7: idle holds the address and done stays low
    repeat (3) @(negedge clk);
    chk("R7 idle addr", 32'(fetch_addr_o), 32'h1300);
    chk("R7 idle done", {31'd0, done_o}, 32'h0);

    // R5: strobe held through the stall cycle with a jump presented
    step_i = 1'b1; jump_i = 1'b1; target_i = 16'h34FF;
    @(negedge clk);
    jump_i = 1'b0; len_i = 2'd1;
    @(negedge clk);
    chk("R3 partial addr in stall", 32'(fetch_addr_o), 32'h3400);
    chk("R3 stall high", {31'd0, stall_o}, 32'h1);
    jump_i = 1'b1; target_i = 16'h0000; len_i = 2'd3;
    @(negedge clk);
    step_i = 1'b0; jump_i = 1'b0;
    chk("R5 addr after stall", 32'(fetch_addr_o), 32'h3500);
    chk("R5 done after stall", {31'd0, done_o}, 32'h1);
    @(negedge clk);
    chk("R5 addr held", 32'(fetch_addr_o), 32'h3500);
    chk("R7 done pulse ends", {30'd0, stall_o, done_o}, 32'h0);

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 addr after re-reset", 32'(fetch_addr_o), 32'h0);
    @(negedge clk);
    chk("R1 stall/done after re-reset", {30'd0, stall_o, done_o}, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule